// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Strobe Controller

This block sits between a synchronous request port and an external asynchronous static RAM. The RAM is byte-wide, has an 18-bit address, a split data bus (the pad ring joins the two halves), an active-low and an active-high chip select, an output enable and a write enable. Each accepted request is a single-byte read or write. The controller turns it into a fixed strobe sequence. Every phase is a whole number of clock cycles, worked out with a ceiling from a clock-period parameter and a speed-grade parameter (55 ns or 70 ns). This meets every minimum pulse, setup, access and bus-release time of the RAM.

The host offers a request with `req_valid_i`. It is accepted on any rising edge where `req_ready_o` is high. Write data and address are held for the whole access. A read result shows on `rsp_rdata_o` during the single cycle in which `rsp_done_o` is high. A separate low-power input puts the RAM in retention. The controller holds both chip selects inactive while that input is high. When the input drops, the controller waits one read-cycle time before it accepts work again.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: After reset, `req_ready_o`=1, `mem_sel_n_o`=1, `mem_sel_o`=1, `mem_we_n_o`=1, `mem_oe_n_o`=1, `mem_dq_oe_o`=0 and `rsp_done_o`=0.
- R2: A write runs in three parts. First there is one cycle with the selects active (`mem_sel_n_o`=0, `mem_sel_o`=1) and `mem_we_n_o`=1. Then `mem_we_n_o` is low for WP cycles. Then there are WEND cycles with `mem_we_n_o` high and the selects still active. Address and write data stay stable throughout.
- R3: `mem_dq_oe_o` is high only while `mem_we_n_o` is low. It rises WHZ cycles after `mem_we_n_o` falls, and it falls in the same cycle in which `mem_we_n_o` rises.
- R4: A read holds the selects active and `mem_oe_n_o` low for RD cycles. `mem_dq_i` is sampled at the edge that ends the last of those cycles. That byte appears on `rsp_rdata_o` in the following cycle.
- R5: After a read, `req_ready_o` returns OHZ cycles after `mem_oe_n_o` rises. The controller does not drive the bus in that gap.
- R6: For a clock period T and grade G, phase lengths are ceil(t/T), each at least 1. WHZ comes from the bus release after write enable (20/25 ns). DW comes from data setup (25/30 ns). WP = max(ceil(pulse), ceil(address-to-end) - 1, WHZ + DW), with pulse 45/55 ns and address-to-end 45/60 ns. WEND = max(1, ceil(cycle) - 1 - WP), with cycle 55/70 ns. RD = max(ceil(access), ceil(output-enable access), ceil(cycle)), with access 55/70 ns and output-enable access 30/35 ns. OHZ comes from the output-enable release (20/25 ns). At T = 5 ns and grade 55 this gives WHZ=4, WP=9, WEND=1, RD=11, OHZ=4 and a wake wait of 11.
- R7: `rsp_done_o` is a single-cycle pulse at the end of every access. `req_ready_o` is low from the accept edge until the access completes. A request is taken only when valid and ready are both high.
- R8: With the block idle, `lp_req_i` high and no request valid, the next cycle shows `mem_sel_o`=0, `mem_sel_n_o`=1 and `req_ready_o`=0. This holds for as long as `lp_req_i` stays high.
- R9: After `lp_req_i` falls, the selects stay inactive (`mem_sel_o`=0) and `req_ready_o` stays low for one read-cycle time (11 cycles at default). Then `mem_sel_o` returns to 1 and `req_ready_o` to 1.
- R10: If `req_valid_i` and `lp_req_i` are both high while the block is idle, the request is accepted first. Low power is entered only after the access completes.
- R11: `mem_we_n_o` and `mem_oe_n_o` are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Controller can accept a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 18 | Byte address |
| req_wdata_i | input | 8 | Write byte |
| lp_req_i | input | 1 | Low-power retention request |
| rsp_done_o | output | 1 | One-cycle access completion pulse |
| rsp_rdata_o | output | 8 | Read byte, valid with rsp_done_o |
| mem_addr_o | output | 18 | RAM address |
| mem_sel_n_o | output | 1 | Active-low chip select |
| mem_sel_o | output | 1 | Active-high chip select |
| mem_we_n_o | output | 1 | Active-low write enable |
| mem_oe_n_o | output | 1 | Active-low output enable |
| mem_dq_o | output | 8 | Data driven toward the RAM |
| mem_dq_oe_o | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 8 | Data returned from the RAM |

## Verification
A wrong phase counter or state shows up at the pins within one cycle of the faulty transition. It appears as a write strobe that is one cycle too long or too short, a drive enable that overlaps the RAM's release window, or an output enable that rises before the access time has passed. The bench rebuilds the expected strobe pattern independently on every cycle, so such faults are reported on the cycle they appear. A capture made too early returns the filler byte that the bench's RAM model drives before the access time elapses, and the mismatch appears on the completion pulse. A wrong stored value is found on the later read-back.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WSET, ST_WPUL, ST_WEND, ST_RACC, ST_RTRN, ST_SLEEP, ST_WAKE
  } ctrl_st_e;

  // selectors for the speed-grade limit table
  localparam int LIM_CYCLE   = 0;  // read/write cycle time
  localparam int LIM_WPULSE  = 1;  // write enable low width
  localparam int LIM_ADR_END = 2;  // address valid to end of write
  localparam int LIM_DSETUP  = 3;  // data valid before end of write
  localparam int LIM_WE_HIZ  = 4;  // RAM output release after write enable low
  localparam int LIM_ACCESS  = 5;  // address access
  localparam int LIM_OE_ACC  = 6;  // output enable access
  localparam int LIM_OE_HIZ  = 7;  // RAM output release after output enable high

  function automatic int lim_ns(input int grade, input int which);
    int r;
    if (grade >= 70) begin
      unique case (which)
        LIM_CYCLE:   r = 70;
        LIM_WPULSE:  r = 55;
        LIM_ADR_END: r = 60;
        LIM_DSETUP:  r = 30;
        LIM_WE_HIZ:  r = 25;
        LIM_ACCESS:  r = 70;
        LIM_OE_ACC:  r = 35;
        default:     r = 25;
      endcase
    end else begin
      unique case (which)
        LIM_CYCLE:   r = 55;
        LIM_WPULSE:  r = 45;
        LIM_ADR_END: r = 45;
        LIM_DSETUP:  r = 25;
        LIM_WE_HIZ:  r = 20;
        LIM_ACCESS:  r = 55;
        LIM_OE_ACC:  r = 30;
        default:     r = 20;
      endcase
    end
    return r;
  endfunction

  function automatic int ns_to_cyc(input int ns, input int clk_ps);
    int c;
    c = (ns * 1000 + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] len_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || restart_i) cnt_q <= '0;
    else if (cnt_q != '1)   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == len_i - 1'b1);
endmodule

// File: rtl/sram_io_regs.sv
`timescale 1ns/1ps
module sram_io_regs #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              drive_i,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  output logic [DATA_W-1:0] rdata_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      addr_o  <= '0;
      dq_o    <= '0;
      dq_oe_o <= 1'b0;
      rdata_o <= '0;
    end else begin
      if (load_i) begin
        addr_o <= addr_i;
        dq_o   <= wdata_i;
      end
      dq_oe_o <= drive_i;
      if (capture_i) rdata_o <= dq_i;
    end
  end
endmodule

// File: rtl/sram_strobe_ctrl.sv
`timescale 1ns/1ps
module sram_strobe_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int CLK_PS   = 5000,
  parameter int SPEED_NS = 55,
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 8,
  parameter int CNT_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              lp_req_i,
  output logic              rsp_done_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_sel_n_o,
  output logic              mem_sel_o,
  output logic              mem_we_n_o,
  output logic              mem_oe_n_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);
  // phase lengths in clock cycles
  localparam int WHZ_C  = ns_to_cyc(lim_ns(SPEED_NS, LIM_WE_HIZ), CLK_PS);
  localparam int DW_C   = ns_to_cyc(lim_ns(SPEED_NS, LIM_DSETUP), CLK_PS);
  localparam int WC_C   = ns_to_cyc(lim_ns(SPEED_NS, LIM_CYCLE), CLK_PS);
  localparam int WP_C   = imax(imax(ns_to_cyc(lim_ns(SPEED_NS, LIM_WPULSE), CLK_PS),
                                    ns_to_cyc(lim_ns(SPEED_NS, LIM_ADR_END), CLK_PS) - 1),
                               WHZ_C + DW_C);
  localparam int WEND_C = imax(1, WC_C - 1 - WP_C);
  localparam int RD_C   = imax(imax(ns_to_cyc(lim_ns(SPEED_NS, LIM_ACCESS), CLK_PS),
                                    ns_to_cyc(lim_ns(SPEED_NS, LIM_OE_ACC), CLK_PS)), WC_C);
  localparam int OHZ_C  = ns_to_cyc(lim_ns(SPEED_NS, LIM_OE_HIZ), CLK_PS);
  localparam int RDR_C  = WC_C;

  ctrl_st_e         st_q, st_d;
  logic [CNT_W-1:0] ph_len, ph_cnt;
  logic [CNT_W:0]   cnt_nx;
  logic             ph_last, accept, drive_d, capture, done_d;

  always_comb begin
    unique case (st_q)
      ST_WPUL: ph_len = CNT_W'(WP_C);
      ST_WEND: ph_len = CNT_W'(WEND_C);
      ST_RACC: ph_len = CNT_W'(RD_C);
      ST_RTRN: ph_len = CNT_W'(OHZ_C);
      ST_WAKE: ph_len = CNT_W'(RDR_C);
      default: ph_len = CNT_W'(1);
    endcase
  end

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .restart_i(st_d != st_q),
    .len_i    (ph_len),
    .cnt_o    (ph_cnt),
    .last_o   (ph_last)
  );

  assign accept = (st_q == ST_IDLE) && req_valid_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (req_valid_i) st_d = req_write_i ? ST_WSET : ST_RACC;
                else if (lp_req_i) st_d = ST_SLEEP;
      ST_WSET:  if (ph_last) st_d = ST_WPUL;
      ST_WPUL:  if (ph_last) st_d = ST_WEND;
      ST_WEND:  if (ph_last) st_d = ST_IDLE;
      ST_RACC:  if (ph_last) st_d = ST_RTRN;
      ST_RTRN:  if (ph_last) st_d = ST_IDLE;
      ST_SLEEP: if (!lp_req_i) st_d = ST_WAKE;
      ST_WAKE:  if (ph_last) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  // drive the bus only after the RAM has released it, stop as write enable rises
  assign cnt_nx  = {1'b0, ph_cnt} + 1'b1;
  assign drive_d = (st_q == ST_WPUL) && !ph_last && (cnt_nx >= (CNT_W+1)'(WHZ_C));
  assign capture = (st_q == ST_RACC) && ph_last;
  assign done_d  = ((st_q == ST_RACC) || (st_q == ST_WEND)) && ph_last;

  sram_io_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_io (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .load_i   (accept),
    .addr_i   (req_addr_i),
    .wdata_i  (req_wdata_i),
    .drive_i  (drive_d),
    .capture_i(capture),
    .dq_i     (mem_dq_i),
    .addr_o   (mem_addr_o),
    .dq_o     (mem_dq_o),
    .dq_oe_o  (mem_dq_oe_o),
    .rdata_o  (rsp_rdata_o)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      st_q        <= ST_IDLE;
      req_ready_o <= 1'b1;
      rsp_done_o  <= 1'b0;
      mem_sel_n_o <= 1'b1;
      mem_sel_o   <= 1'b1;
      mem_we_n_o  <= 1'b1;
      mem_oe_n_o  <= 1'b1;
    end else begin
      st_q        <= st_d;
      req_ready_o <= (st_d == ST_IDLE);
      rsp_done_o  <= done_d;
      mem_sel_n_o <= !((st_d == ST_WSET) || (st_d == ST_WPUL) ||
                       (st_d == ST_WEND) || (st_d == ST_RACC));
      mem_sel_o   <= !((st_d == ST_SLEEP) || (st_d == ST_WAKE));
      mem_we_n_o  <= (st_d != ST_WPUL);
      mem_oe_n_o  <= (st_d != ST_RACC);
    end
  end
endmodule

// File: rtl/sram_ctrl_chk.sv
`timescale 1ns/1ps
module sram_ctrl_chk #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8,
  parameter int WP_C   = 9,
  parameter int RD_C   = 11
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              req_ready_o,
  input logic              rsp_done_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_sel_n_o,
  input logic              mem_sel_o,
  input logic              mem_we_n_o,
  input logic              mem_oe_n_o,
  input logic [DATA_W-1:0] mem_dq_o,
  input logic              mem_dq_oe_o
);
  logic [15:0] we_run, oe_run;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      we_run <= '0;
      oe_run <= '0;
    end else begin
      we_run <= mem_we_n_o ? 16'd0 : we_run + 16'd1;
      oe_run <= mem_oe_n_o ? 16'd0 : oe_run + 16'd1;
    end
  end

  // R11
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !(!mem_we_n_o && !mem_oe_n_o));

  // R3
  drive_in_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    mem_dq_oe_o |-> (!mem_we_n_o && !mem_sel_n_o && mem_sel_o));

  // R3
  drive_stop_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(mem_dq_oe_o) |-> $rose(mem_we_n_o));

  // R2
  sel_before_we_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(mem_we_n_o) |-> ($past(!mem_sel_n_o) && !mem_sel_n_o));

  // R2
  sel_after_we_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(mem_we_n_o) |-> !mem_sel_n_o);

  // R2
  hold_in_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!mem_we_n_o && $past(!mem_we_n_o)) |-> ($stable(mem_addr_o) && $stable(mem_dq_o)));

  // R6
  pulse_len_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(mem_we_n_o) |-> (we_run == 16'(WP_C)));

  // R4
  read_len_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(mem_oe_n_o) |-> (oe_run == 16'(RD_C)));

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    rsp_done_o |=> !rsp_done_o);

  // R8
  sleep_sel_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !mem_sel_o |-> (mem_sel_n_o && !req_ready_o));
endmodule

bind sram_strobe_ctrl sram_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WP_C(WP_C), .RD_C(RD_C)
) u_chk (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .req_ready_o(req_ready_o),
  .rsp_done_o (rsp_done_o),
  .mem_addr_o (mem_addr_o),
  .mem_sel_n_o(mem_sel_n_o),
  .mem_sel_o  (mem_sel_o),
  .mem_we_n_o (mem_we_n_o),
  .mem_oe_n_o (mem_oe_n_o),
  .mem_dq_o   (mem_dq_o),
  .mem_dq_oe_o(mem_dq_oe_o)
);

// File: tb/sram_strobe_ctrl_tb.sv
`timescale 1ns/1ps
module sram_strobe_ctrl_tb_top;
  localparam int CLK_PS = 5000;

  function automatic int cyc(input int ns);
    int c;
    c = (ns * 1000 + CLK_PS - 1) / CLK_PS;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // R6: expected phase lengths for the 55 ns grade at 5 ns
  localparam int WHZ  = cyc(20);
  localparam int WP   = mx(mx(cyc(45), cyc(45) - 1), cyc(20) + cyc(25));
  localparam int WEND = mx(1, cyc(55) - 1 - WP);
  localparam int RD   = mx(mx(cyc(55), cyc(30)), cyc(55));
  localparam int OHZ  = cyc(20);
  localparam int RDR  = cyc(55);
  localparam int WR_TOTAL = 1 + WP + WEND;

  localparam int M_IDLE = 0, M_WR = 1, M_RD = 2, M_SLP = 3, M_WAKE = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, lp_req = 1'b0;
  logic [17:0] req_addr = '0;
  logic [7:0]  req_wdata = '0, dq_in = '0;
  logic        req_ready, rsp_done, sel_n, sel, we_n, oe_n, dq_oe;
  logic [7:0]  rsp_rdata, dq_out;
  logic [17:0] mem_addr;

  always #2.5 clk = ~clk;

  sram_strobe_ctrl dut_i (
    .clk_i(clk), .rst_i(rst),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .lp_req_i(lp_req),
    .rsp_done_o(rsp_done), .rsp_rdata_o(rsp_rdata),
    .mem_addr_o(mem_addr), .mem_sel_n_o(sel_n), .mem_sel_o(sel),
    .mem_we_n_o(we_n), .mem_oe_n_o(oe_n), .mem_dq_o(dq_out),
    .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_in)
  );

  int n_tests = 0, n_fail = 0, cycles = 0;
  // reference model state
  int m = M_IDLE, e = 0;
  logic [17:0] m_addr;
  logic [7:0]  m_data, m_rd;
  bit          m_done = 0, m_done_rd = 0, accepted = 0;
  logic [7:0]  exp_mem [int];
  // RAM device model state
  logic [7:0]  dev_mem [int];
  logic [7:0]  lat_d;
  logic [17:0] lat_a;
  bit          lat_v = 0;
  int          rd_cnt = 0, we_run = 0, oe_run = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cycles);
    end
  endtask

  task automatic model_edge();
    m_done = 0; m_done_rd = 0; accepted = 0;
    case (m)
      M_IDLE: if (req_valid) begin
                m = req_write ? M_WR : M_RD; e = 1; accepted = 1;
                m_addr = req_addr; m_data = req_wdata;
                if (req_write) exp_mem[int'(req_addr)] = req_wdata;
              end else if (lp_req) m = M_SLP;
      M_WR:   if (e == WR_TOTAL) begin m = M_IDLE; m_done = 1; end else e++;
      M_RD:   begin
                if (e == RD) begin m_done = 1; m_done_rd = 1; m_rd = exp_mem[int'(m_addr)]; end
                if (e == RD + OHZ) m = M_IDLE; else e++;
              end
      M_SLP:  if (!lp_req) begin m = M_WAKE; e = 1; end
      M_WAKE: if (e == RDR) m = M_IDLE; else e++;
      default: m = M_IDLE;
    endcase
  endtask

  task automatic compare();
    bit x_sel_act, x_we_lo, x_oe_lo, x_drv;
    string rtag;
    x_sel_act = (m == M_WR) || (m == M_RD && e <= RD);
    x_we_lo   = (m == M_WR) && e >= 2 && e <= 1 + WP;
    x_oe_lo   = (m == M_RD) && e <= RD;
    x_drv     = (m == M_WR) && e >= 2 + WHZ && e <= 1 + WP;
    rtag = (m == M_RD) ? "R5" : (m == M_WAKE) ? "R9" : "R7";
    chk(req_ready == (m == M_IDLE), rtag, "ready", req_ready, m == M_IDLE);
    chk(sel_n == !x_sel_act, "R2", "sel_n", sel_n, !x_sel_act);
    chk(sel == !(m == M_SLP || m == M_WAKE), "R8", "sel", sel, !(m == M_SLP || m == M_WAKE));
    chk(we_n == !x_we_lo, "R2", "we_n", we_n, !x_we_lo);
    chk(oe_n == !x_oe_lo, "R4", "oe_n", oe_n, !x_oe_lo);
    chk(dq_oe == x_drv, "R3", "dq_oe", dq_oe, x_drv);
    chk(!(!we_n && !oe_n), "R11", "we_n&oe_n both low", {we_n, oe_n}, 2'b11);
    chk(rsp_done == m_done, "R7", "done", rsp_done, m_done);
    if (x_sel_act) chk(mem_addr == m_addr, "R2", "addr", mem_addr, m_addr);
    if (x_drv)     chk(dq_out == m_data, "R2", "wdata", dq_out, m_data);
    if (m_done_rd) chk(rsp_rdata == m_rd, "R4", "rdata", rsp_rdata, m_rd);
    // R6: strobe run lengths
    if (!we_n) we_run++;
    else if (we_run != 0) begin chk(we_run == WP, "R6", "we low cycles", we_run, WP); we_run = 0; end
    if (!oe_n) oe_run++;
    else if (oe_run != 0) begin chk(oe_run == RD, "R6", "oe low cycles", oe_run, RD); oe_run = 0; end
  endtask

  task automatic device();
    if (!sel_n && sel && !we_n && dq_oe) begin
      lat_d = dq_out; lat_a = mem_addr; lat_v = 1;
    end else if (we_n && lat_v) begin
      dev_mem[int'(lat_a)] = lat_d; lat_v = 0;
    end
    if (!sel_n && sel && !oe_n && we_n) begin
      rd_cnt++;
      dq_in = (rd_cnt >= RD && dev_mem.exists(int'(mem_addr))) ? dev_mem[int'(mem_addr)] : 8'h96;
    end else begin
      rd_cnt = 0; dq_in = 8'h00;
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    cycles++;
    if (cycles > 50000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      summary();
      $finish;
    end
    compare();
    device();
  endtask

  task automatic issue(input bit wr, input logic [17:0] a, input logic [7:0] d);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    do step(); while (!accepted);
    req_valid = 0;
  endtask

  task automatic wait_idle();
    do step(); while (m != M_IDLE);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    chk(req_ready && sel_n && sel && we_n && oe_n && !dq_oe && !rsp_done, "R1", "reset outputs",
        {req_ready, sel_n, sel, we_n, oe_n, dq_oe, rsp_done}, 7'b1111100);
    step();
    // writes at corner addresses
    issue(1, 18'h00000, 8'h3C); wait_idle();
    issue(1, 18'h3FFFF, 8'hC3); wait_idle();
    issue(1, 18'h15555, 8'hA5);
    // back-to-back: request held valid while busy
    issue(1, 18'h2AAAA, 8'h5A);
    issue(0, 18'h00000, 8'h00);
    issue(0, 18'h3FFFF, 8'h00);
    issue(0, 18'h15555, 8'h00);
    issue(0, 18'h2AAAA, 8'h00); wait_idle();
    // overwrite then read
    issue(1, 18'h15555, 8'h0F); issue(0, 18'h15555, 8'h00); wait_idle();
    // R8/R9: low-power entry and wake recovery
    lp_req = 1;
    repeat (20) step();
    chk(!sel && sel_n && !req_ready, "R8", "sleep pins", {sel, sel_n, req_ready}, 3'b010);
    lp_req = 0;
    wait_idle();
    chk(req_ready && sel, "R9", "ready after wake", {req_ready, sel}, 2'b11);
    // R10: request wins over low-power in the same cycle
    lp_req = 1; req_valid = 1; req_write = 1; req_addr = 18'h01234; req_wdata = 8'hE7;
    step();
    req_valid = 0;
    chk(!sel_n && sel, "R10", "write taken first", {sel_n, sel}, 2'b01);
    wait_idle();
    repeat (5) step();
    lp_req = 0;
    wait_idle();
    issue(0, 18'h01234, 8'h00); wait_idle();
    issue(0, 18'h00000, 8'h00); wait_idle();
    repeat (3) step();
    summary();
    $finish;
  end
endmodule